// File: doc/BRIEF.md
# Paged Address Translator

This block turns 16-bit virtual addresses into 15-bit physical addresses for a small paged memory system. Pages are 4 KB, so the top four address bits select one of 16 virtual pages and the low twelve bits pass through unchanged as the offset. A physical frame number is three bits wide, which gives 8 frames. The 16 page-table entries live in internal registers. Software installs or clears them through a table write port and can inspect any of them through a table read port.

A request carries an address and a read/write flag, and it is accepted under a valid/ready handshake. On the clock edge that accepts a request, the block registers one of three results: a physical address, an absence fault, or a protection fault. On the same edge it updates the referenced and modified bits of the entry it used. Each entry also holds a no-cache flag, which is returned with a successful translation so that pages mapped to devices can skip caching. Fault servicing, page eviction and disk transfer are left to software, which rewrites entries after a fault.

Top module: `paged_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and all 16 table entries read back as 0. An entry of 0 is absent.
- R2: When the entry is present and allows the access, the response carries `rsp_paddr = {pfn, addr[11:0]}` with both fault flags at 0. The response is valid right after the edge that accepts the request.
- R3: An access to an entry whose present bit (bit 3) is 0 sets `rsp_absent` and clears `rsp_prot`. It drives `rsp_paddr` and `rsp_nocache` to 0 and leaves the entry unchanged.
- R4: A write to a present entry whose write-permission bit (bit 5) is 0 sets `rsp_prot` and clears `rsp_absent`. It drives `rsp_paddr` to 0 and leaves the entry unchanged.
- R5: A read from a present entry whose read-permission bit (bit 4) is 0 sets `rsp_prot` and leaves the entry unchanged.
- R6: A successful access sets the referenced bit (bit 7) of its entry. A successful write also sets the modified bit (bit 8). A successful read leaves the modified bit as it was.
- R7: On a successful translation, `rsp_nocache` equals the entry's no-cache bit (bit 6). On any fault it is 0.
- R8: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. While `rsp_valid` is 1 and `rsp_ready` is 0, the response outputs hold steady, and a waiting request is neither accepted nor allowed to change any entry.
- R9: A table write stores `tbl_wdata` at `tbl_widx`. The bits are: pfn in [2:0], present [3], read [4], write [5], no-cache [6], referenced [7], modified [8]. The stored value can be read on the next cycle. If a request using that entry is accepted in the same cycle, that request is translated with the old entry, the written value wins over the status update, and the next request uses the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 15 | Physical address (0 on fault) |
| rsp_nocache | output | 1 | Translated page bypasses caching |
| rsp_absent | output | 1 | Page not present fault |
| rsp_prot | output | 1 | Permission fault |
| tbl_we | input | 1 | Table write enable |
| tbl_widx | input | 4 | Entry to write |
| tbl_wdata | input | 9 | Entry contents to write |
| tbl_ridx | input | 4 | Entry to read back |
| tbl_rdata | output | 9 | Contents of entry `tbl_ridx` (combinational) |

## Verification
A request accepted at a rising edge has its response fields and its status-bit update in place right after that same edge. A table write likewise shows at the read port right after the edge that takes it. The bench therefore drives inputs on the falling edge and samples one time unit after the following rising edge. It predicts every result from its own copy of the table, taken before that edge. For stalls, it samples again after further edges and expects unchanged outputs and unchanged entries.

// File: rtl/pgx_pkg.sv
// Shared widths and the page-table entry layout for the paged translator.
// Assumes: a single-level table indexed directly by the virtual page number.
package pgx_pkg;
    localparam int VA_W  = 16;
    localparam int OFF_W = 12;
    localparam int PFN_W = 3;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int PAGES = 1 << VPN_W;

    // Entry layout, MSB first; software depends on these bit positions.
    typedef struct packed {
        logic             modified;
        logic             referenced;
        logic             nocache;
        logic             wr_ok;
        logic             rd_ok;
        logic             present;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);
endpackage

// File: rtl/pgx_table.sv
// Page-table register file: one write port for software, one lookup port
// for translation, one read-back port, and a status update port that sets
// the referenced/modified bits. A software write to an entry beats a status
// update to that same entry in the same cycle.
module pgx_table
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VPN_W-1:0] widx,
    input  pte_t             wdata,
    input  logic             upd_en,
    input  logic [VPN_W-1:0] upd_idx,
    input  logic             upd_mod,
    input  logic [VPN_W-1:0] look_idx,
    output pte_t             look_pte,
    input  logic [VPN_W-1:0] rd_idx,
    output pte_t             rd_pte
);
    pte_t tbl [PAGES];

    // Hold entries: reset clears, software writes win, then status updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) tbl[i] <= '0;
        end else begin
            for (int i = 0; i < PAGES; i++) begin
                if (we && widx == VPN_W'(i)) begin
                    tbl[i] <= wdata;
                end else if (upd_en && upd_idx == VPN_W'(i)) begin
                    tbl[i].referenced <= 1'b1;
                    if (upd_mod) tbl[i].modified <= 1'b1;
                end
            end
        end
    end

    // Combinational read ports.
    assign look_pte = tbl[look_idx];
    assign rd_pte   = tbl[rd_idx];

    assert_ref_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(we && widx == upd_idx)) |=> tbl[$past(upd_idx)].referenced);

    assert_mod_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_mod && !(we && widx == upd_idx)) |=> tbl[$past(upd_idx)].modified);

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> tbl[$past(widx)] == $past(wdata));
endmodule

// File: rtl/pgx_decide.sv
// Translation decision for one access: checks presence first, then the
// permission matching the access kind, and forms the physical address.
// Assumes: the entry is the one selected by the request's page number.
module pgx_decide
    import pgx_pkg::*;
(
    input  pte_t             pte,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    output logic             hit,
    output logic             absent,
    output logic             prot,
    output logic [PA_W-1:0]  paddr,
    output logic             nocache
);
    logic allowed;

    // Pick the permission bit for this access kind.
    always_comb allowed = is_write ? pte.wr_ok : pte.rd_ok;

    // Classify the access and form the outputs; faults zero the address.
    always_comb begin
        absent  = !pte.present;
        prot    = pte.present && !allowed;
        hit     = pte.present && allowed;
        paddr   = hit ? {pte.pfn, offset} : '0;
        nocache = hit && pte.nocache;
    end
endmodule

// File: rtl/paged_xlate.sv
// Top of the paged translator: splits the request address, looks up the
// entry, registers one response per accepted request under valid/ready, and
// sends status updates for successful accesses back to the table.
// Assumes: a response stays in place until taken; one request in flight.
module paged_xlate
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_addr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_nocache,
    output logic             rsp_absent,
    output logic             rsp_prot,
    input  logic             tbl_we,
    input  logic [VPN_W-1:0] tbl_widx,
    input  logic [PTE_W-1:0] tbl_wdata,
    input  logic [VPN_W-1:0] tbl_ridx,
    output logic [PTE_W-1:0] tbl_rdata
);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] offset;
    logic             accept;
    pte_t             look_pte;
    pte_t             rd_pte;
    logic             hit_c, absent_c, prot_c, nocache_c;
    logic [PA_W-1:0]  paddr_c;

    // Address split and handshake.
    assign vpn       = req_addr[VA_W-1:OFF_W];
    assign offset    = req_addr[OFF_W-1:0];
    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign tbl_rdata = rd_pte;

    pgx_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we),
        .widx     (tbl_widx),
        .wdata    (pte_t'(tbl_wdata)),
        .upd_en   (accept && hit_c),
        .upd_idx  (vpn),
        .upd_mod  (req_write),
        .look_idx (vpn),
        .look_pte (look_pte),
        .rd_idx   (tbl_ridx),
        .rd_pte   (rd_pte)
    );

    pgx_decide u_decide (
        .pte      (look_pte),
        .offset   (offset),
        .is_write (req_write),
        .hit      (hit_c),
        .absent   (absent_c),
        .prot     (prot_c),
        .paddr    (paddr_c),
        .nocache  (nocache_c)
    );

    // Response register: load on accept, drop valid once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_paddr   <= '0;
            rsp_nocache <= 1'b0;
            rsp_absent  <= 1'b0;
            rsp_prot    <= 1'b0;
        end else if (accept) begin
            rsp_valid   <= 1'b1;
            rsp_paddr   <= paddr_c;
            rsp_nocache <= nocache_c;
            rsp_absent  <= absent_c;
            rsp_prot    <= prot_c;
        end else if (rsp_ready) begin
            rsp_valid   <= 1'b0;
        end
    end

    assert_one_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_absent && rsp_prot));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_absent || rsp_prot)) |-> (rsp_paddr == '0 && !rsp_nocache));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(accept) && !rsp_absent && !rsp_prot)
            |-> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_absent) && $stable(rsp_prot) && $stable(rsp_nocache)));
endmodule

// File: tb/tb_paged_xlate.sv
module tb_paged_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [15:0] req_addr;
    logic        rsp_valid, rsp_ready;
    logic [14:0] rsp_paddr;
    logic        rsp_nocache, rsp_absent, rsp_prot;
    logic        tbl_we;
    logic [3:0]  tbl_widx, tbl_ridx;
    logic [8:0]  tbl_wdata, tbl_rdata;

    int tests = 0;
    int fails = 0;
    logic [8:0] mdl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache),
        .rsp_absent(rsp_absent), .rsp_prot(rsp_prot),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
        .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected response fields {absent, prot, nocache, paddr} from the model.
    function automatic logic [17:0] expect_rsp(input logic [8:0] e, input logic [15:0] a, input logic w);
        logic allowed;
        allowed = w ? e[5] : e[4];
        if (!e[3])        return {1'b1, 1'b0, 1'b0, 15'd0};
        else if (!allowed) return {1'b0, 1'b1, 1'b0, 15'd0};
        else               return {1'b0, 1'b0, e[6], e[2:0], a[11:0]};
    endfunction

    // Entry contents expected after an access.
    function automatic logic [8:0] expect_upd(input logic [8:0] e, input logic w);
        logic [8:0] r;
        r = e;
        if (e[3] && (w ? e[5] : e[4])) begin
            r[7] = 1'b1;
            if (w) r[8] = 1'b1;
        end
        return r;
    endfunction

    task automatic read_entry(input logic [3:0] idx, output logic [8:0] val);
        tbl_ridx = idx;
        #1;
        val = tbl_rdata;
    endtask

    task automatic twrite(input logic [3:0] idx, input logic [8:0] d);
        logic [8:0] got;
        @(negedge clk);
        tbl_we = 1'b1; tbl_widx = idx; tbl_wdata = d;
        @(posedge clk); #1;
        tbl_we = 1'b0;
        mdl[idx] = d;
        read_entry(idx, got);
        chk("R9 table write readback", 32'(got), 32'(d));
    endtask

    task automatic access(input logic [15:0] a, input logic w, input string tag);
        logic [17:0] exp;
        logic [8:0]  got;
        logic [3:0]  v;
        v = a[15:12];
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; rsp_ready = 1'b1;
        exp = expect_rsp(mdl[v], a, w);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " response"}, 32'({rsp_absent, rsp_prot, rsp_nocache, rsp_paddr}), 32'(exp));
        mdl[v] = expect_upd(mdl[v], w);
        read_entry(v, got);
        chk({tag, " entry status"}, 32'(got), 32'(mdl[v]));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [8:0] got;
        void'($urandom(32'd4321));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        rsp_ready = 1'b1; tbl_we = 1'b0; tbl_widx = '0; tbl_wdata = '0; tbl_ridx = '0;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
        for (int i = 0; i < 16; i++) begin
            read_entry(4'(i), got);
            chk("R1 entry cleared", 32'(got), 32'd0);
        end
        @(negedge clk); rst_n = 1'b1;

        // R3 absent page
        access(16'h3123, 1'b0, "R3 absent read");
        // R2/R6/R7 present read-write page, no-cache set
        twrite(4'h1, 9'b0_0_1_1_1_1_101);
        access(16'h1abc, 1'b0, "R2 R6 R7 read hit");
        access(16'h1fff, 1'b1, "R6 write sets modified");
        // R4 write to read-only page
        twrite(4'h2, 9'b0_0_0_0_1_1_011);
        access(16'h2010, 1'b1, "R4 write to read-only");
        access(16'h2010, 1'b0, "R2 read of read-only");
        // R5 read of write-only page
        twrite(4'h4, 9'b0_0_0_1_0_1_111);
        access(16'h4000, 1'b0, "R5 read of write-only");
        access(16'h4fff, 1'b1, "R6 write-only write");

        // R8 stall: response held, second request waits
        twrite(4'h6, 9'b0_0_0_1_1_1_010);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h1555; req_write = 1'b0; rsp_ready = 1'b0;
        @(posedge clk); #1;
        chk("R8 first accepted", 32'(rsp_paddr), 32'({3'b101, 12'h555}));
        @(negedge clk);
        req_addr = 16'h6777; req_write = 1'b1;
        #1;
        chk("R8 ready low during stall", 32'(req_ready), 32'd0);
        repeat (2) @(posedge clk);
        #1;
        chk("R8 response held", 32'({rsp_valid, rsp_paddr}), 32'({1'b1, 3'b101, 12'h555}));
        read_entry(4'h6, got);
        chk("R8 waiting request changes nothing", 32'(got), 32'(mdl[6]));
        @(negedge clk);
        req_valid = 1'b0; rsp_ready = 1'b1;
        #1;
        chk("R8 ready with rsp_ready", 32'(req_ready), 32'd1);
        @(posedge clk); #1;
        chk("R8 valid drops when taken", 32'(rsp_valid), 32'd0);

        // R9 same-cycle table write and translation of that entry
        twrite(4'h5, 9'b0_0_0_1_1_1_010);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h5abc; req_write = 1'b1; rsp_ready = 1'b1;
        tbl_we = 1'b1; tbl_widx = 4'h5; tbl_wdata = 9'b0_0_0_1_1_1_110;
        @(posedge clk); #1;
        req_valid = 1'b0; tbl_we = 1'b0;
        chk("R9 old entry used", 32'(rsp_paddr), 32'({3'b010, 12'habc}));
        mdl[5] = 9'b0_0_0_1_1_1_110;
        read_entry(4'h5, got);
        chk("R9 write wins over status", 32'(got), 32'(mdl[5]));
        access(16'h5001, 1'b0, "R9 next request new entry");

        // Random phase over table contents and accesses
        for (int i = 0; i < 16; i++) twrite(4'(i), 9'($urandom));
        for (int n = 0; n < 300; n++) begin
            if (($urandom % 10) == 0) twrite(4'($urandom), 9'($urandom));
            access(16'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule